// File: doc/BRIEF.md
# Double-Buffered Filter Coefficient Bank

This block stores two full sets of filter coefficients, bank A and bank B, for an audio filter engine that runs in the same design. Each set has a fixed number of signed 16-bit fixed-point coefficients in 1.15 format. A host writes and reads them one byte at a time through a simple register port. The engine reads the coefficients of the live bank through its own index port.

When the engine is stopped, the host can reach either bank freely. When the engine runs and adaptive mode is off, the coefficient space is locked. When the engine runs and adaptive mode is on, every coefficient write goes to the bank the engine is not using. The host can then ask for a swap. The swap waits for the next sample-period start strobe, so the engine never mixes coefficients from both banks within one sample. A status bit follows the live bank.

Top module: `coef_dbuf_bank`

## Requirements
- R1: After reset, bank A is live, the status, adaptive-enable and swap-request bits are 0, and in both banks coefficient k holds 0x7FFF when k is a multiple of GROUP (default 5) and 0x0000 otherwise.
- R2: Host address bit [ADDR_W-1] selects bank A (0) or bank B (1). The lower bits are a byte index: byte 2k holds the high byte and byte 2k+1 holds the low byte of coefficient k. While the engine is stopped, host writes and reads act on the bank the address selects.
- R3: A high-byte write only loads a staging register, and the stored coefficient does not change. The following low-byte write stores {staged high byte, low byte} as one 16-bit word.
- R4: While the engine runs with adaptive mode off, host coefficient writes are ignored and host coefficient reads return 0x00.
- R5: While the engine runs with adaptive mode on, a coefficient write lands in the bank that is not live, whichever bank the address selects. The live coefficients seen by the engine do not change.
- R6: The control register sits at byte index all-ones with bank bit 0. Its bit 2 is adaptive enable, bit 1 is the live-bank status (read-only) and bit 0 is the swap request. A swap request written while the engine runs in adaptive mode stays pending until the next sample-start strobe. On that strobe the live bank and the status bit toggle and the request clears itself.
- R7: A swap request written while the engine is stopped or adaptive mode is off reads back 0 and never swaps. A pending request is dropped if the engine stops before the strobe.
- R8: The engine port returns coefficient engIdx of the live bank, and returns 0 when engIdx is NUM_COEF or above.
- R9: Host read data appears on the cycle after the read strobe and holds until the next read. Unmapped addresses read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| engRun | input | 1 | Filter engine is running |
| sampleStart | input | 1 | One-cycle pulse at the start of each sample period |
| hostWr | input | 1 | Host byte write strobe |
| hostRd | input | 1 | Host byte read strobe |
| hostAddr | input | ADDR_W | Host byte address: bank bit above the byte index |
| hostWrData | input | BYTE_W | Host write byte |
| hostRdData | output | BYTE_W | Host read byte, registered |
| engIdx | input | CIDX_W | Engine coefficient index |
| engCoef | output | 2*BYTE_W | Live-bank coefficient at engIdx |
| liveBank | output | 1 | Live bank: 0 = A, 1 = B |

## Verification
The hardest state to reach is a second swap while bank B is live. Reaching it means writing a full bank with the engine running in adaptive mode, holding a request across idle cycles, and firing the strobe. The stimulus therefore runs a full adaptive refill addressed to bank A and swaps, then runs a second refill addressed to bank B and swaps back. After each refill the engine port is swept to show that the live bank did not move. Once the engine stops, both banks are read back so that each refill can be seen in the bank it was steered to. A request that is cancelled because the engine stops, and a strobe that lands with nothing pending, are also driven.

// File: rtl/cdb_pkg.sv
package cdb_pkg;
  // Width of coefficient index fields carried between control and datapath.
  localparam int IDX_W = 8;

  // Strobes from the control section to the coefficient store.
  typedef struct packed {
    logic             stageHi;    // load staging register with the write byte
    logic             commitLo;   // store {stage, byte} into one coefficient
    logic             commitBank; // bank that receives the commit
    logic [IDX_W-1:0] wrIdx;      // coefficient index of the write
    logic [IDX_W-1:0] rdIdx;      // coefficient index of a host read
    logic             rdBank;     // bank of a host read
    logic             rdHi;       // host read wants the high byte
  } cdb_strobe_t;
endpackage

// File: rtl/cdb_store.sv
module cdb_store
  import cdb_pkg::*;
#(
  parameter int NUM_COEF = 70,
  parameter int GROUP    = 5,
  parameter int BYTE_W   = 8,
  localparam int COEF_W  = 2 * BYTE_W,
  localparam int CIDX_W  = $clog2(NUM_COEF)
) (
  input  logic              clk,
  input  logic              rstN,
  input  cdb_strobe_t       strb,
  input  logic [BYTE_W-1:0] wrByte,
  input  logic              liveBank,
  input  logic              engRun,
  input  logic [CIDX_W-1:0] engIdx,
  output logic [BYTE_W-1:0] coefByte,
  output logic [COEF_W-1:0] engCoef
);

  localparam logic [COEF_W-1:0] UNITY = {1'b0, {(COEF_W-1){1'b1}}};

  logic [BYTE_W-1:0] stageReg;
  logic [COEF_W-1:0] bankMem [2][NUM_COEF];
  logic [COEF_W-1:0] rdWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stageReg <= '0;
    else if (strb.stageHi) stageReg <= wrByte;
  end

  for (genvar b = 0; b < 2; b++) begin : gBank
    for (genvar k = 0; k < NUM_COEF; k++) begin : gCoef
      localparam logic [COEF_W-1:0] DEF = ((k % GROUP) == 0) ? UNITY : '0;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) bankMem[b][k] <= DEF;
        else if (strb.commitLo && (strb.commitBank == 1'(b)) &&
                 (strb.wrIdx == IDX_W'(k)))
          bankMem[b][k] <= {stageReg, wrByte};
      end
    end
  end

  always_comb begin
    rdWord = '0;
    if (int'(strb.rdIdx) < NUM_COEF) rdWord = bankMem[strb.rdBank][strb.rdIdx[CIDX_W-1:0]];
    coefByte = strb.rdHi ? rdWord[COEF_W-1:BYTE_W] : rdWord[BYTE_W-1:0];
  end

  always_comb begin
    engCoef = '0;
    if (int'(engIdx) < NUM_COEF) engCoef = bankMem[liveBank][engIdx];
  end

  // R4 R5: a running engine never sees a write into its live bank
  a_r5_commit_misses_live: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commitLo && engRun) |-> (strb.commitBank != liveBank));

  // R3: staging register changes only on a high-byte strobe
  a_r3_stage_holds: assert property (@(posedge clk) disable iff (!rstN)
    !strb.stageHi |=> $stable(stageReg));

endmodule

// File: rtl/cdb_ctrl.sv
module cdb_ctrl
  import cdb_pkg::*;
#(
  parameter int NUM_COEF = 70,
  parameter int BYTE_W   = 8,
  localparam int BIW     = $clog2(2 * NUM_COEF + 1),
  localparam int ADDR_W  = BIW + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              engRun,
  input  logic              sampleStart,
  input  logic              hostWr,
  input  logic              hostRd,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [BYTE_W-1:0] hostWrData,
  input  logic [BYTE_W-1:0] coefByte,
  output cdb_strobe_t       strb,
  output logic              liveBank,
  output logic [BYTE_W-1:0] hostRdData
);

  localparam logic [BIW:0] COEF_BYTES = (BIW+1)'(2 * NUM_COEF);

  logic [BIW-1:0] byteIdx;
  logic           addrBank;
  logic           isCoef;
  logic           isCtrl;
  logic           isLo;
  logic           locked;
  logic           ctrlWr;
  logic           adaptEn;
  logic           swapPend;
  logic           doSwap;
  logic [BYTE_W-1:0] ctrlByte;

  assign byteIdx  = hostAddr[BIW-1:0];
  assign addrBank = hostAddr[BIW];
  assign isLo     = byteIdx[0];
  assign isCoef   = ({1'b0, byteIdx} < COEF_BYTES);
  assign isCtrl   = !addrBank && (byteIdx == '1);
  assign locked   = engRun && !adaptEn;
  assign ctrlWr   = hostWr && isCtrl;
  assign doSwap   = swapPend && sampleStart && engRun && adaptEn;
  assign ctrlByte = BYTE_W'({adaptEn, liveBank, swapPend});

  always_comb begin
    strb            = '0;
    strb.stageHi    = hostWr && isCoef && !isLo && !locked;
    strb.commitLo   = hostWr && isCoef && isLo && !locked;
    strb.commitBank = engRun ? ~liveBank : addrBank;
    strb.wrIdx      = IDX_W'(byteIdx[BIW-1:1]);
    strb.rdIdx      = IDX_W'(byteIdx[BIW-1:1]);
    strb.rdBank     = addrBank;
    strb.rdHi       = !isLo;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      adaptEn  <= 1'b0;
      liveBank <= 1'b0;
      swapPend <= 1'b0;
    end else begin
      if (ctrlWr) adaptEn <= hostWrData[2];
      if (doSwap) begin
        liveBank <= ~liveBank;
        swapPend <= 1'b0;
      end else if (ctrlWr) begin
        swapPend <= hostWrData[0] && hostWrData[2] && engRun;
      end else if (!engRun || !adaptEn) begin
        swapPend <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) hostRdData <= '0;
    else if (hostRd) begin
      if (isCtrl) hostRdData <= ctrlByte;
      else if (isCoef && !locked) hostRdData <= coefByte;
      else hostRdData <= '0;
    end
  end

  // R6: the live bank moves only on a sample-start strobe
  a_r6_swap_on_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !sampleStart |=> $stable(liveBank));

  // R6: a pending request is gone after the strobe that sees it
  a_r6_self_clear: assert property (@(posedge clk) disable iff (!rstN)
    (swapPend && sampleStart) |=> !swapPend);

  // R7: nothing stays pending once the engine is stopped
  a_r7_idle_no_pend: assert property (@(posedge clk) disable iff (!rstN)
    !engRun |=> !swapPend);

  // R7: a pending request implies adaptive mode
  a_r7_pend_needs_adapt: assert property (@(posedge clk) disable iff (!rstN)
    swapPend |-> adaptEn);

endmodule

// File: rtl/coef_dbuf_bank.sv
module coef_dbuf_bank
  import cdb_pkg::*;
#(
  parameter int NUM_COEF = 70,
  parameter int GROUP    = 5,
  parameter int BYTE_W   = 8,
  localparam int CIDX_W  = $clog2(NUM_COEF),
  localparam int ADDR_W  = $clog2(2 * NUM_COEF + 1) + 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                engRun,
  input  logic                sampleStart,
  input  logic                hostWr,
  input  logic                hostRd,
  input  logic [ADDR_W-1:0]   hostAddr,
  input  logic [BYTE_W-1:0]   hostWrData,
  output logic [BYTE_W-1:0]   hostRdData,
  input  logic [CIDX_W-1:0]   engIdx,
  output logic [2*BYTE_W-1:0] engCoef,
  output logic                liveBank
);

  cdb_strobe_t       strb;
  logic [BYTE_W-1:0] coefByte;

  cdb_ctrl #(.NUM_COEF(NUM_COEF), .BYTE_W(BYTE_W)) uCtrl (
    .clk(clk), .rstN(rstN), .engRun(engRun), .sampleStart(sampleStart),
    .hostWr(hostWr), .hostRd(hostRd), .hostAddr(hostAddr),
    .hostWrData(hostWrData), .coefByte(coefByte), .strb(strb),
    .liveBank(liveBank), .hostRdData(hostRdData)
  );

  cdb_store #(.NUM_COEF(NUM_COEF), .GROUP(GROUP), .BYTE_W(BYTE_W)) uStore (
    .clk(clk), .rstN(rstN), .strb(strb), .wrByte(hostWrData),
    .liveBank(liveBank), .engRun(engRun), .engIdx(engIdx),
    .coefByte(coefByte), .engCoef(engCoef)
  );

endmodule

// File: tb/sim_coef_dbuf_bank.sv
module sim_coef_dbuf_bank;
  localparam int N = 70;
  localparam int G = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic engRun = 1'b0, sampleStart = 1'b0, hostWr = 1'b0, hostRd = 1'b0;
  logic [8:0] hostAddr = '0;
  logic [7:0] hostWrData = '0;
  logic [7:0] hostRdData;
  logic [6:0] engIdx = '0;
  logic [15:0] engCoef;
  logic liveBank;

  int nRun = 0, nFail = 0;
  bit done = 0;
  logic [15:0] model [2][N];

  always #5 clk = ~clk;

  coef_dbuf_bank u0 (.*);

  function automatic logic [15:0] defVal(int k);
    return ((k % G) == 0) ? 16'h7FFF : 16'h0000;
  endfunction

  function automatic logic [15:0] pat(int b, int k, int seed);
    return 16'((k * 16'h0301) + (seed * 16'h1357) + (b * 16'h5A5A));
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic hWrite(logic [8:0] a, logic [7:0] d);
    @(negedge clk); hostWr = 1; hostAddr = a; hostWrData = d;
    @(negedge clk); hostWr = 0;
  endtask

  task automatic hRead(logic [8:0] a, output logic [7:0] d);
    @(negedge clk); hostRd = 1; hostAddr = a;
    @(negedge clk); hostRd = 0; d = hostRdData;
  endtask

  task automatic wrCoef(int b, int k, logic [15:0] v);
    hWrite({1'(b), 8'(2*k)}, v[15:8]);
    hWrite({1'(b), 8'(2*k+1)}, v[7:0]);
  endtask

  task automatic rdCoef(int b, int k, output logic [15:0] v);
    logic [7:0] hi, lo;
    hRead({1'(b), 8'(2*k)}, hi);
    hRead({1'(b), 8'(2*k+1)}, lo);
    v = {hi, lo};
  endtask

  task automatic engSweep(string req, int b);
    for (int k = 0; k < N; k++) begin
      @(negedge clk); engIdx = 7'(k); #1;
      chk(req, engCoef, model[b][k]);
    end
  endtask

  task automatic hostSweep(string req);
    logic [15:0] v;
    for (int b = 0; b < 2; b++)
      for (int k = 0; k < N; k++) begin
        rdCoef(b, k, v);
        chk(req, v, model[b][k]);
      end
  endtask

  task automatic strobe();
    @(negedge clk); sampleStart = 1;
    @(negedge clk); sampleStart = 0;
  endtask

  localparam logic [8:0] CTRL = 9'h0FF;

  initial begin
    logic [7:0] d;
    logic [15:0] v;
    for (int b = 0; b < 2; b++)
      for (int k = 0; k < N; k++) model[b][k] = defVal(k);
    repeat (3) @(negedge clk);
    rstN = 1;

    // R1 reset state
    chk("R1 live", liveBank, 0);
    hRead(CTRL, d); chk("R1 ctrl", d, 8'h00);
    engSweep("R1 engine defaults", 0);
    hostSweep("R1 host defaults");

    // R2 stopped writes go to addressed bank
    for (int b = 0; b < 2; b++)
      for (int k = 0; k < N; k++) begin
        model[b][k] = pat(b, k, 1 + b);
        wrCoef(b, k, model[b][k]);
      end
    hostSweep("R2 readback");
    engSweep("R8 engine sees A", 0);

    // R3 staging
    hWrite({1'b0, 8'd6}, 8'hC3);
    @(negedge clk); engIdx = 7'd3; #1; chk("R3 hi alone", engCoef, model[0][3]);
    rdCoef(0, 3, v); chk("R3 hi alone host", v, model[0][3]);
    hWrite({1'b0, 8'd7}, 8'h3C);
    model[0][3] = 16'hC33C;
    @(negedge clk); engIdx = 7'd3; #1; chk("R3 commit", engCoef, 16'hC33C);

    // R8 R9 out of range
    @(negedge clk); engIdx = 7'd100; #1; chk("R8 range", engCoef, 0);
    hRead({1'b0, 8'd200}, d); chk("R9 unmapped", d, 0);
    hRead({1'b1, 8'hFF}, d); chk("R9 unmapped ctrl B", d, 0);

    // R4 lock
    @(negedge clk); engRun = 1;
    for (int k = 0; k < 4; k++) begin
      wrCoef(0, k, 16'hDEAD); wrCoef(1, k, 16'hBEEF);
      rdCoef(0, k, v); chk("R4 locked read", v, 0);
    end
    engSweep("R4 engine unchanged", 0);
    hRead(CTRL, d); chk("R4 ctrl", d, 8'h00);

    // R7 request while not adaptive
    hWrite(CTRL, 8'h01); hRead(CTRL, d); chk("R7 non-adaptive", d, 8'h00);
    strobe(); chk("R7 no swap", liveBank, 0);
    @(negedge clk); engRun = 0;
    hostSweep("R4 banks untouched");
    hWrite(CTRL, 8'h05); hRead(CTRL, d); chk("R7 stopped", d, 8'h04);
    strobe(); chk("R7 stopped no swap", liveBank, 0);
    @(negedge clk); engRun = 1;
    hWrite(CTRL, 8'h05); hRead(CTRL, d); chk("R6 pending", d, 8'h05);
    @(negedge clk); engRun = 0;
    @(negedge clk); engRun = 1;
    hRead(CTRL, d); chk("R7 cancel", d, 8'h04);
    strobe(); chk("R7 cancel no swap", liveBank, 0);

    // R5 adaptive writes addressed to A land in B
    for (int k = 0; k < N; k++) begin
      model[1][k] = pat(0, k, 7);
      wrCoef(0, k, model[1][k]);
    end
    engSweep("R5 live A unchanged", 0);
    hWrite(CTRL, 8'h05);
    repeat (5) @(negedge clk);
    chk("R6 wait strobe", liveBank, 0);
    @(negedge clk); engIdx = 7'd1; #1; chk("R6 no early swap", engCoef, model[0][1]);
    strobe();
    chk("R6 swapped", liveBank, 1);
    hRead(CTRL, d); chk("R6 status", d, 8'h06);
    engSweep("R6 engine B", 1);
    strobe(); chk("R6 single swap", liveBank, 1);

    // R5 with B live: writes addressed to B land in A
    for (int k = 0; k < N; k++) begin
      model[0][k] = pat(1, k, 9);
      wrCoef(1, k, model[0][k]);
    end
    engSweep("R5 live B unchanged", 1);
    hWrite(CTRL, 8'h05); strobe();
    hRead(CTRL, d); chk("R6 back to A", d, 8'h04);
    engSweep("R6 engine A", 0);

    // R2 stopped readback of both banks
    @(negedge clk); engRun = 0;
    hostSweep("R2 final");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    #20ms;
    if (!done) begin
      nRun++; nFail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule